// File: doc/BRIEF.md
# JTAG-to-SPI Flash Bridge

This block sits behind a user-defined JTAG data register and lets a debug host reach the SPI configuration flash through the TAP. The host first loads a user instruction into IR. The TAP decodes it and raises `user_sel`, and the TAP drives `shift_dr` high while it is in Shift-DR. In that window the bridge ignores zero bits on TDI until the first one bit arrives. That bit is the start marker. The bridge then takes a 32-bit length word, most significant bit first, which holds the number of SPI bits minus one. It drives the flash chip select for exactly that many bits plus one. During that time TDI goes straight to MOSI, TCK is passed to SCK, and MISO comes back on TDO.

A sequencer walks four states. HUNT waits for the marker. In HUNT a one bit while shifting gives HUNT→HDR. HDR takes the 32 length bits into the down-counter. The last length bit gives HDR→XFER. XFER holds chip select low and decrements the counter on every TCK rise. When the counter is zero on a rise, XFER→HOLD. HOLD keeps chip select high until Shift-DR is left. Losing `shift_dr` or `user_sel` gives any state→HUNT at the next rise, and chip select drops at once. `tap_tlr` is asynchronous and forces HUNT.

SCK is the AND of TCK with an enable that is taken on the falling TCK edge. MISO is sampled on the rising edge, and TDO is updated on the falling edge. The returned data is therefore late by exactly one bit, which is the slot this TAP occupies in the chain. The host counts that slot in its padding.

Top module: `jspi_bridge`

## Requirements
- R1: While `shift_dr` and `user_sel` are both high, TDI bits of value 0 in HUNT are ignored. The first TDI 1 is the marker. `cs_n` stays high until the whole length word has been taken.
- R2: The 32 bits after the marker, most significant first, form L. `cs_n` goes low after the rising edge that takes the last length bit. It stays low for exactly L+1 further rising edges, and the flash sees exactly L+1 SCK rising edges.
- R3: L=0 gives a one-bit transfer. L=7 gives a bare one-byte command with no address or data.
- R4: While `cs_n` is low, `mosi` equals `tdi` with no added delay.
- R5: SCK rises only on TCK rises where the falling-edge enable was set while `cs_n` was low. Outside a transfer `sck` stays low.
- R6: `tdo` changes on the falling TCK edge. It then shows the value `miso` had at the preceding rising edge, so there is exactly one TCK of latency. For the read-ID command 0x9F the three ID bytes come back most significant bit first.
- R7: When the count ends, `cs_n` returns high and stays high for the rest of Shift-DR, even if TDI keeps carrying ones.
- R8: A low `shift_dr` or `user_sel` forces `cs_n` high in the same TCK phase, and the bridge returns to HUNT. With `user_sel` low, no transfer takes place.
- R9: `tap_tlr` asynchronously forces HUNT, `cs_n` high, `sck` low and `tdo` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock, also the SPI clock source |
| tap_tlr | input | 1 | TAP in Test-Logic-Reset, asynchronous reset, active high |
| shift_dr | input | 1 | TAP in Shift-DR |
| user_sel | input | 1 | User instruction selecting this bridge is in IR |
| tdi | input | 1 | JTAG serial data in |
| miso | input | 1 | Flash serial data out |
| tdo | output | 1 | JTAG serial data out |
| sck | output | 1 | Gated SPI clock |
| mosi | output | 1 | Flash serial data in |
| cs_n | output | 1 | Flash chip select, active low |

## Verification
Two events can land on the same TCK rise. The first is the terminal count: the bench keeps driving ones on TDI after every frame, so the final SPI bit meets a would-be new marker, and the per-cycle chip-select model shows whether the sequencer holds or restarts. The second is leaving Shift-DR while SCK is live: `shift_dr` is dropped in the high phase of TCK in the middle of a read. The bench then confirms that chip select rises in that same phase and that no further SCK rise reaches the flash model. A fresh read-ID frame afterwards must return the correct bytes.

// File: rtl/jspi_pkg.sv
package jspi_pkg;
    typedef enum logic [1:0] {
        ST_HUNT,
        ST_HDR,
        ST_XFER,
        ST_HOLD
    } jspi_state_e;
endpackage

// File: rtl/jspi_seq.sv
module jspi_seq
    import jspi_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic tck,
    input  logic tlr,
    input  logic active,
    input  logic tdi,
    output logic in_xfer
);
    localparam int IDX_W = $clog2(LEN_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LEN_W - 1);

    jspi_state_e      st, st_nx;
    logic [IDX_W-1:0] hdr_idx;
    logic [LEN_W-1:0] remain;
    logic             hdr_last;
    logic             remain_zero;

    assign hdr_last    = (hdr_idx == IDX_LAST);
    assign remain_zero = (remain == '0);

    // next-state logic
    always_comb begin
        st_nx = st;
        if (!active) begin
            st_nx = ST_HUNT;
        end else begin
            unique case (st)
                ST_HUNT: if (tdi)         st_nx = ST_HDR;
                ST_HDR:  if (hdr_last)    st_nx = ST_XFER;
                ST_XFER: if (remain_zero) st_nx = ST_HOLD;
                ST_HOLD:                  st_nx = ST_HOLD;
            endcase
        end
    end

    // state register
    always_ff @(posedge tck or posedge tlr) begin
        if (tlr) st <= ST_HUNT;
        else     st <= st_nx;
    end

    // length word shifts straight into the down-counter
    always_ff @(posedge tck or posedge tlr) begin
        if (tlr) begin
            hdr_idx <= '0;
            remain  <= '0;
        end else begin
            unique case (st)
                ST_HUNT: hdr_idx <= '0;
                ST_HDR: begin
                    hdr_idx <= hdr_idx + IDX_W'(1);
                    remain  <= {remain[LEN_W-2:0], tdi};
                end
                ST_XFER: if (!remain_zero) remain <= remain - LEN_W'(1);
                ST_HOLD: hdr_idx <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_xfer = (st == ST_XFER) && active;
    end
endmodule

// File: rtl/jspi_sck_gate.sv
module jspi_sck_gate (
    input  logic tck,
    input  logic tlr,
    input  logic run,
    output logic sck
);
    logic en_lo;

    // enable changes only while tck is low, so the AND cannot glitch
    always_ff @(negedge tck or posedge tlr) begin
        if (tlr) en_lo <= 1'b0;
        else     en_lo <= run;
    end

    assign sck = tck & en_lo;
endmodule

// File: rtl/jspi_ret.sv
module jspi_ret (
    input  logic tck,
    input  logic tlr,
    input  logic miso,
    output logic tdo
);
    logic miso_q;

    always_ff @(posedge tck or posedge tlr) begin
        if (tlr) miso_q <= 1'b0;
        else     miso_q <= miso;
    end

    always_ff @(negedge tck or posedge tlr) begin
        if (tlr) tdo <= 1'b0;
        else     tdo <= miso_q;
    end
endmodule

// File: rtl/jspi_bridge.sv
module jspi_bridge #(
    parameter int LEN_W = 32
) (
    input  logic tck,
    input  logic tap_tlr,
    input  logic shift_dr,
    input  logic user_sel,
    input  logic tdi,
    input  logic miso,
    output logic tdo,
    output logic sck,
    output logic mosi,
    output logic cs_n
);
    logic active;
    logic in_xfer;

    assign active = shift_dr & user_sel;

    jspi_seq #(.LEN_W(LEN_W)) u_seq (
        .tck     (tck),
        .tlr     (tap_tlr),
        .active  (active),
        .tdi     (tdi),
        .in_xfer (in_xfer)
    );

    jspi_sck_gate u_gate (
        .tck (tck),
        .tlr (tap_tlr),
        .run (in_xfer),
        .sck (sck)
    );

    jspi_ret u_ret (
        .tck  (tck),
        .tlr  (tap_tlr),
        .miso (miso),
        .tdo  (tdo)
    );

    assign cs_n = ~in_xfer;
    assign mosi = tdi;
endmodule

// File: rtl/jspi_bridge_chk.sv
module jspi_bridge_chk (
    input logic tck,
    input logic tap_tlr,
    input logic shift_dr,
    input logic user_sel,
    input logic miso,
    input logic tdo,
    input logic sck,
    input logic cs_n
);
    logic [1:0] warm;
    logic       ready;

    always_ff @(posedge tck or posedge tap_tlr) begin
        if (tap_tlr)          warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end
    assign ready = (warm >= 2'd2);

    // R1
    cs_fall_chk: assert property (@(posedge tck) disable iff (tap_tlr)
        (ready && $fell(cs_n)) |-> $past(shift_dr && user_sel));

    // R8
    exit_release_chk: assert property (@(posedge tck) disable iff (tap_tlr)
        !(shift_dr && user_sel) |-> cs_n);

    // R7
    hold_high_chk: assert property (@(posedge tck) disable iff (tap_tlr)
        (ready && $rose(cs_n) && shift_dr && user_sel && $past(shift_dr && user_sel)) |=> cs_n);

    // R5
    sck_gate_chk: assert property (@(negedge tck) disable iff (tap_tlr)
        (ready && sck) |-> $past(!cs_n));

    // R6
    tdo_latency_chk: assert property (@(posedge tck) disable iff (tap_tlr)
        ready |-> (tdo == $past(miso)));
endmodule

bind jspi_bridge jspi_bridge_chk u_chk (
    .tck      (tck),
    .tap_tlr  (tap_tlr),
    .shift_dr (shift_dr),
    .user_sel (user_sel),
    .miso     (miso),
    .tdo      (tdo),
    .sck      (sck),
    .cs_n     (cs_n)
);

// File: tb/jspi_bridge_test.sv
`timescale 1ns/1ps
module jspi_bridge_test;
    logic tck = 1'b0;
    logic tap_tlr, shift_dr, user_sel, tdi, miso;
    logic tdo, sck, mosi, cs_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 tck = ~tck;

    jspi_bridge uut (
        .tck(tck), .tap_tlr(tap_tlr), .shift_dr(shift_dr), .user_sel(user_sel),
        .tdi(tdi), .miso(miso), .tdo(tdo), .sck(sck), .mosi(mosi), .cs_n(cs_n)
    );

    // flash model: counts SCK rises, answers read-ID
    localparam logic [23:0] FLASH_ID = 24'hC22018;
    logic [7:0] f_cmd;
    int         f_cnt;

    initial begin
        f_cmd = 8'h00;
        f_cnt = 0;
    end

    always @(negedge cs_n) begin
        f_cnt = 0;
        f_cmd = 8'h00;
        miso  = 1'b0;
    end

    always @(posedge sck) begin
        if (f_cnt < 8) f_cmd = {f_cmd[6:0], mosi};
        f_cnt = f_cnt + 1;
    end

    always @(negedge sck) begin
        if (!cs_n && f_cmd == 8'h9F && f_cnt >= 8 && f_cnt < 32)
            miso = FLASH_ID[23 - (f_cnt - 8)];
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic bitval(input int i, input int pre, input int len,
                                    input logic [63:0] payload);
        logic [31:0] lv;
        lv = len[31:0];
        if (i < pre)        return 1'b0;
        if (i == pre)       return 1'b1;
        if (i <= pre + 32)  return lv[31 - (i - pre - 1)];
        if (i <= pre + 33 + len) return payload[63 - (i - pre - 33)];
        return 1'b1;        // trailing ones probe the hold state
    endfunction

    // abort_kind: 0 none, 1 drop shift_dr, 2 pulse tap_tlr
    task automatic run_frame(input int pre, input int len, input logic [63:0] payload,
                             input int nextra, input logic sel,
                             input int abort_at, input int abort_kind);
        int          total;
        logic [23:0] rx;
        bit          is_id;
        bit          aborted;
        total   = pre + 34 + len + nextra;
        is_id   = (payload[63:56] == 8'h9F) && (len == 31) && sel && (abort_kind == 0);
        rx      = '0;
        aborted = 1'b0;
        @(posedge tck); #1;
        shift_dr = 1'b1;
        user_sel = sel;
        for (int i = 0; i < total; i++) begin
            if (abort_kind != 0 && i == abort_at) begin
                if (abort_kind == 1) begin
                    shift_dr = 1'b0;
                    #1;
                    check("R8", "cs_n same phase after exit", 64'(cs_n), 64'd1);
                end else begin
                    tap_tlr = 1'b1;
                    #1;
                    check("R9", "cs_n on async reset", 64'(cs_n), 64'd1);
                    check("R9", "sck on async reset", 64'(sck), 64'd0);
                    check("R9", "tdo on async reset", 64'(tdo), 64'd0);
                    @(negedge tck); #1;
                    tap_tlr = 1'b0;
                    tdi     = 1'b0;
                end
                for (int k = 0; k < 3; k++) begin
                    @(posedge tck); #2;
                    check("R8", "cs_n stays high after abort", 64'(cs_n), 64'd1);
                    check("R5", "no sck after abort", 64'(sck), 64'd0);
                end
                aborted = 1'b1;
                break;
            end
            @(negedge tck); #1;
            tdi = bitval(i, pre, len, payload);
            @(posedge tck); #2;
            begin
                bit exp_cs_low;
                bit exp_sck;
                int j;
                exp_cs_low = sel && (i >= pre + 32) && (i <= pre + 32 + len);
                exp_sck    = sel && (i >= pre + 33) && (i <= pre + 33 + len);
                // R1 R2 R3 R7: chip-select window against the frame plan
                check(i < pre + 32 ? "R1" : (i > pre + 32 + len ? "R7" : "R2"),
                      "cs_n window", 64'(cs_n), 64'(!exp_cs_low));
                check("R5", "sck gating", 64'(sck), 64'(exp_sck));
                if (!cs_n) check("R4", "mosi follows tdi", 64'(mosi), 64'(tdi));
                j = i - (pre + 42);
                if (is_id && j >= 0 && j < 24) begin
                    rx[23 - j] = tdo;
                    check("R6", "id bit on tdo", 64'(tdo), 64'(FLASH_ID[23 - j]));
                end
            end
        end
        if (!aborted && sel)
            check(len == 0 ? "R3" : "R2", "flash sck rise count", 64'(f_cnt), 64'(len + 1));
        if (is_id)
            check("R6", "read-ID bytes", 64'(rx), 64'(FLASH_ID));
        @(posedge tck); #1;
        shift_dr = 1'b0;
        user_sel = 1'b0;
        tdi      = 1'b0;
        repeat (2) @(posedge tck);
    endtask

    initial begin
        tap_tlr  = 1'b1;
        shift_dr = 1'b0;
        user_sel = 1'b0;
        tdi      = 1'b0;
        miso     = 1'b0;
        repeat (3) @(posedge tck);
        #2;
        check("R9", "cs_n in reset", 64'(cs_n), 64'd1);
        check("R9", "sck in reset", 64'(sck), 64'd0);
        check("R9", "tdo in reset", 64'(tdo), 64'd0);
        @(negedge tck); #1;
        tap_tlr = 1'b0;
        repeat (3) @(posedge tck);

        // R1 R2 R6 R7: read-ID with leading bypass zeros
        run_frame(3, 31, {8'h9F, 56'h0}, 6, 1'b1, -1, 0);
        // R3: bare command byte, no marker padding
        run_frame(0, 7, {8'h06, 56'h0}, 4, 1'b1, -1, 0);
        // R3: single-bit transfer
        run_frame(5, 0, {1'b1, 63'h0}, 4, 1'b1, -1, 0);
        // R2 R4: long write-like frame
        run_frame(1, 63, {8'h02, 24'h001000, 32'hA5C3_0F96}, 3, 1'b1, -1, 0);
        // R8: instruction not selected, no transfer
        run_frame(2, 31, {8'h9F, 56'h0}, 3, 1'b0, -1, 0);
        // R8: leave Shift-DR mid-read, then a fresh read
        run_frame(2, 31, {8'h9F, 56'h0}, 3, 1'b1, 2 + 45, 1);
        run_frame(4, 31, {8'h9F, 56'h0}, 5, 1'b1, -1, 0);
        // R9: async reset mid-transfer, then a fresh command
        run_frame(1, 31, {8'h9F, 56'h0}, 3, 1'b1, 1 + 38, 2);
        run_frame(0, 31, {8'h9F, 56'h0}, 2, 1'b1, -1, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule